// File: doc/BRIEF.md
# Indirect-Access Real-Time-Clock Register Controller

This block puts a real-time clock behind a small 16-bit host register port. The host does not address the clock's byte registers directly. It loads an output data byte, then writes a command word that names a register index and a direction. The controller raises a busy flag, waits a fixed number of clock cycles, and then carries out the read or the write. When the access completes, busy drops and a done flag rises. A read leaves its result in a read buffer that the host can see.

Behind the port sits a bank of 40 byte registers. Indexes 0 to 6 hold a BCD calendar that advances on a once-per-second strobe. Index 7 is a power-control byte whose top three bits, when written, can request a chip reset or a power-off. Index 8 counts a 32 Hz strobe. Index 31 holds a checksum of indexes 7 to 30. Status flags for done and for the seconds tick are gated by mode bits and combined into one interrupt line.

Top module: `rtc_ctl`

## Requirements
- R1: After reset, status is 0000, the read buffer is 00, irq and both request outputs are low, and the calendar reads 00:00:00, weekday 0, day 01, month 01, year 00.
- R2: A host write to offset 4 while status bit 0 (busy) is clear sets busy on the next cycle. The access completes exactly DELAY cycles after that write is accepted: busy clears and status bit 1 (done) sets.
- R3: A write to offset 4 while busy is ignored, and the access already in flight completes with its own command.
- R4: In the command byte, bit 7 selects a write, bits 6:1 give the register index, and bit 0 marks the address invalid. An invalid command changes no register but still completes with done set.
- R5: A write to an index from 9 to 30 stores the byte last written to offset 6 (low byte). A read of any index below 40 copies that register into the read buffer.
- R6: Writes to indexes 32 to 63 change nothing, and indexes 32 to 39 read as 00. A read of an index of 40 or more leaves the read buffer unchanged.
- R7: After any write to indexes 7 to 31, index 31 holds the 8-bit sum of indexes 7 to 30.
- R8: A write to index 7 replaces only bits 4:0. If the written bits 7:5 are 110, bits 7:5 become 110 and reset_req pulses high for one cycle. If they are 111, bits 7:5 are kept and poweroff_req pulses high for one cycle.
- R9: Writes to indexes 0 to 6 load seconds, minutes, hours, weekday (0 to 6), day, month and year in BCD. Each 1 Hz strobe advances the calendar by one second, with rollover through month lengths and leap years (year divisible by 4).
- R10: Each 1 Hz strobe sets status bit 2.
- R11: Each 32 Hz strobe increments index 8 modulo 256.
- R12: A host write to offset 2 clears each of status bits 3:1 whose data bit is 1. Busy is not affected.
- R13: irq is high exactly when (status bit 1 and mode bit 1) or (status bit 2 and mode bit 2). The mode register is written at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_ofs | input | 3 | Host byte offset: 0 mode, 2 status clear, 4 command, 6 output data; bit 0 ignored |
| host_wdata | input | 16 | Host write data |
| tick_1hz | input | 1 | One-cycle seconds strobe |
| tick_32hz | input | 1 | One-cycle 32 Hz strobe |
| status_o | output | 4 | Status: bit 0 busy, bit 1 done, bit 2 second, bit 3 spare |
| rdbuf_o | output | 8 | Read buffer, the result of the last read access |
| irq | output | 1 | Combined interrupt |
| reset_req | output | 1 | One-cycle reset request |
| poweroff_req | output | 1 | One-cycle power-off request |

## Verification
The bench builds the controller with DELAY set to 4. This keeps every posted access short, so the bench can sweep the whole general register range, every index past the bank, and each power-control code in a few thousand cycles, and can measure the busy window to the exact cycle. Because the seconds strobe is driven directly, the bench can run thousands of ticks and compare the result against time arithmetic. It also walks the minute, hour, day, month, leap-February and year boundaries.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_REGS  = 40;
    localparam int IDX_PWR   = 7;
    localparam int IDX_TICK  = 8;
    localparam int IDX_CSUM  = 31;
    localparam int CSUM_LO   = 7;
    localparam int CSUM_HI   = 30;
    localparam int CAL_LAST  = 6;

    typedef enum logic [1:0] {
        HR_MODE = 2'd0,
        HR_CLR  = 2'd1,
        HR_CMD  = 2'd2,
        HR_OBUF = 2'd3
    } host_reg_e;

    // command byte: bit 7 write, bits 6:1 index, bit 0 invalid
    typedef struct packed {
        logic       wr;
        logic [5:0] idx;
        logic       inval;
    } cmd_t;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] day;
        logic [7:0] dow;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9) return {b[7:4] + 4'd1, 4'd0};
        return b + 8'd1;
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] bin;
        bin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
        case (mon)
            8'h02:                      return (bin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_idx,
    input  logic [7:0] wr_data,
    output cal_t       cal
);

    cal_t cal_q, nxt;

    always_comb begin
        nxt = cal_q;
        if (cal_q.sec != 8'h59) nxt.sec = bcd_inc(cal_q.sec);
        else begin
            nxt.sec = 8'h00;
            if (cal_q.min != 8'h59) nxt.min = bcd_inc(cal_q.min);
            else begin
                nxt.min = 8'h00;
                if (cal_q.hr != 8'h23) nxt.hr = bcd_inc(cal_q.hr);
                else begin
                    nxt.hr  = 8'h00;
                    nxt.dow = (cal_q.dow >= 8'h06) ? 8'h00 : cal_q.dow + 8'd1;
                    if (cal_q.day != month_len(cal_q.mon, cal_q.yr)) nxt.day = bcd_inc(cal_q.day);
                    else begin
                        nxt.day = 8'h01;
                        if (cal_q.mon != 8'h12) nxt.mon = bcd_inc(cal_q.mon);
                        else begin
                            nxt.mon = 8'h01;
                            nxt.yr  = (cal_q.yr == 8'h99) ? 8'h00 : bcd_inc(cal_q.yr);
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q <= '{yr: 8'h00, mon: 8'h01, day: 8'h01, dow: 8'h00,
                       hr: 8'h00, min: 8'h00, sec: 8'h00};
        end else if (wr_en) begin
            case (wr_idx)
                3'd0: cal_q.sec <= wr_data;
                3'd1: cal_q.min <= wr_data;
                3'd2: cal_q.hr  <= wr_data;
                3'd3: cal_q.dow <= wr_data;
                3'd4: cal_q.day <= wr_data;
                3'd5: cal_q.mon <= wr_data;
                3'd6: cal_q.yr  <= wr_data;
                default: ;
            endcase
        end else if (tick) begin
            cal_q <= nxt;
        end
    end

    assign cal = cal_q;

    // R9: a tick with no write always moves the seconds field
    p_sec_moves_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr_en) |=> (cal_q.sec != $past(cal_q.sec)) || ($past(cal_q.sec) == 8'h00));

endmodule

// File: rtl/rtc_access_seq.sv
module rtc_access_seq #(
    parameter int DELAY = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic fire
);

    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    assign fire = busy_q && (cnt_q == CW'(1));
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                cnt_q  <= CW'(DELAY);
            end
        end else begin
            cnt_q <= cnt_q - CW'(1);
            if (fire) busy_q <= 1'b0;
        end
    end

    // R2: completion only from a busy state; busy holds until completion
    p_fire_in_busy_r2: assert property (@(posedge clk) disable iff (rst) fire |-> busy_q);
    p_busy_holds_r2:   assert property (@(posedge clk) disable iff (rst) (busy_q && !fire) |=> busy_q);

endmodule

// File: rtl/rtc_ctl.sv
module rtc_ctl
    import rtc_pkg::*;
#(
    parameter int DELAY = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic [2:0]  host_ofs,
    input  logic [15:0] host_wdata,
    input  logic        tick_1hz,
    input  logic        tick_32hz,
    output logic [3:0]  status_o,
    output logic [7:0]  rdbuf_o,
    output logic        irq,
    output logic        reset_req,
    output logic        poweroff_req
);

    host_reg_e  sel;
    logic       busy, fire, start;
    logic [2:0] flag_q;          // status bits 3:1
    logic [2:0] mode_q;          // mode bits 2:0
    cmd_t       cmd_q;
    logic [7:0] obuf_q, rdbuf_q;
    logic [7:0] bank_q [IDX_PWR:IDX_CSUM];
    logic       csum_pend_q;
    logic [7:0] csum, rd_val, pwr_nxt;
    logic       wr_go, rd_go, cal_wr, bank_wr;
    cal_t       cal;
    logic       unused_bits;

    assign sel   = host_reg_e'(host_ofs[2:1]);
    assign start = host_wr && (sel == HR_CMD) && !busy;
    assign unused_bits = ^{host_ofs[0], host_wdata[15:8], host_wdata[0]};

    rtc_access_seq #(.DELAY(DELAY)) u_seq (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .fire(fire)
    );

    assign wr_go   = fire && !cmd_q.inval && cmd_q.wr;
    assign rd_go   = fire && !cmd_q.inval && !cmd_q.wr && (cmd_q.idx < 6'(NUM_REGS));
    assign cal_wr  = wr_go && (cmd_q.idx <= 6'(CAL_LAST));
    assign bank_wr = wr_go && (cmd_q.idx >= 6'(IDX_PWR)) && (cmd_q.idx <= 6'(IDX_CSUM));

    rtc_calendar u_cal (
        .clk(clk), .rst(rst), .tick(tick_1hz),
        .wr_en(cal_wr), .wr_idx(cmd_q.idx[2:0]), .wr_data(obuf_q), .cal(cal)
    );

    always_comb begin
        csum = 8'h00;
        for (int i = CSUM_LO; i <= CSUM_HI; i++) csum = csum + bank_q[i];
    end

    always_comb begin
        rd_val = 8'h00;
        case (cmd_q.idx)
            6'd0: rd_val = cal.sec;
            6'd1: rd_val = cal.min;
            6'd2: rd_val = cal.hr;
            6'd3: rd_val = cal.dow;
            6'd4: rd_val = cal.day;
            6'd5: rd_val = cal.mon;
            6'd6: rd_val = cal.yr;
            default: ;
        endcase
        for (int i = IDX_PWR; i <= IDX_CSUM; i++)
            if (cmd_q.idx == 6'(i)) rd_val = bank_q[i];
    end

    always_comb begin
        pwr_nxt = {bank_q[IDX_PWR][7:5], obuf_q[4:0]};
        if (obuf_q[7:5] == 3'b110) pwr_nxt[7:5] = 3'b110;
    end

    // host-side registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            obuf_q  <= '0;
            cmd_q   <= '0;
            rdbuf_q <= '0;
            flag_q  <= '0;
        end else begin
            if (host_wr && sel == HR_MODE) mode_q <= host_wdata[2:0];
            if (host_wr && sel == HR_OBUF) obuf_q <= host_wdata[7:0];
            if (start)                     cmd_q  <= cmd_t'(host_wdata[7:0]);
            if (rd_go)                     rdbuf_q <= rd_val;
            flag_q <= (host_wr && sel == HR_CLR) ? (flag_q & ~host_wdata[3:1]) : flag_q;
            if (fire)     flag_q[0] <= 1'b1;
            if (tick_1hz) flag_q[1] <= 1'b1;
        end
    end

    // register bank 7..31, checksum and power requests
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = IDX_PWR; i <= IDX_CSUM; i++) bank_q[i] <= 8'h00;
            csum_pend_q  <= 1'b0;
            reset_req    <= 1'b0;
            poweroff_req <= 1'b0;
        end else begin
            csum_pend_q  <= bank_wr;
            reset_req    <= bank_wr && (cmd_q.idx == 6'(IDX_PWR)) && (obuf_q[7:5] == 3'b110);
            poweroff_req <= bank_wr && (cmd_q.idx == 6'(IDX_PWR)) && (obuf_q[7:5] == 3'b111);
            if (tick_32hz) bank_q[IDX_TICK] <= bank_q[IDX_TICK] + 8'd1;
            if (bank_wr) begin
                if (cmd_q.idx == 6'(IDX_PWR)) bank_q[IDX_PWR] <= pwr_nxt;
                for (int i = IDX_PWR + 1; i <= IDX_CSUM; i++)
                    if (cmd_q.idx == 6'(i)) bank_q[i] <= obuf_q;
            end
            if (csum_pend_q) bank_q[IDX_CSUM] <= csum;
        end
    end

    assign status_o = {flag_q, busy};
    assign rdbuf_o  = rdbuf_q;
    assign irq      = (flag_q[0] && mode_q[1]) || (flag_q[1] && mode_q[2]);

    // R2: busy falling always leaves done set
    p_done_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(status_o[0]) |-> status_o[1]);
    // R3: command held while busy
    p_cmd_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire) |=> $stable(cmd_q));
    // R8: requests exclusive and single-cycle
    p_req_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({reset_req, poweroff_req}));
    p_reset_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !reset_req);
    // R12: status clear cannot drop busy
    p_busy_kept_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && !fire && host_wr && sel == HR_CLR) |=> status_o[0]);
    // R13: no source, no interrupt
    p_irq_source_r13: assert property (@(posedge clk) disable iff (rst)
        irq |-> (status_o[1] || status_o[2]));

endmodule

// File: tb/rtc_ctl_tb.sv
module rtc_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DLY = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [2:0]  host_ofs = 3'd0;
    logic [15:0] host_wdata = 16'h0;
    logic        tick_1hz = 1'b0;
    logic        tick_32hz = 1'b0;
    logic [3:0]  status_o;
    logic [7:0]  rdbuf_o;
    logic        irq, reset_req, poweroff_req;

    int checks = 0;
    int fails = 0;
    int n_rst = 0;
    int n_off = 0;
    logic [7:0] model [7:30];

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_ctl #(.DELAY(DLY)) u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_ofs(host_ofs),
        .host_wdata(host_wdata), .tick_1hz(tick_1hz), .tick_32hz(tick_32hz),
        .status_o(status_o), .rdbuf_o(rdbuf_o), .irq(irq),
        .reset_req(reset_req), .poweroff_req(poweroff_req)
    );

    always @(negedge clk) begin
        if (reset_req) n_rst++;
        if (poweroff_req) n_off++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int ofs, input int data);
        @(negedge clk);
        host_wr = 1'b1; host_ofs = 3'(ofs); host_wdata = 16'(data);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (status_o[0] && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic access(input logic wr, input int idx, input logic inval, output int cyc);
        host_write(4, {8'h0, wr, 6'(idx), inval});
        wait_idle(cyc);
    endtask

    task automatic wr_reg(input int idx, input int val);
        int c;
        host_write(6, val);
        access(1'b1, idx, 1'b0, c);
    endtask

    task automatic rd_reg(input int idx, output int val);
        int c;
        access(1'b0, idx, 1'b0, c);
        val = rdbuf_o;
    endtask

    task automatic pulse1(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_1hz = 1'b1;
        end
        @(negedge clk); tick_1hz = 1'b0;
    endtask

    task automatic set_cal(input int s, input int m, input int h, input int w,
                           input int d, input int mo, input int y);
        wr_reg(0, s); wr_reg(1, m); wr_reg(2, h); wr_reg(3, w);
        wr_reg(4, d); wr_reg(5, mo); wr_reg(6, y);
    endtask

    task automatic chk_cal(input string req, input int s, input int m, input int h,
                           input int w, input int d, input int mo, input int y);
        int v;
        rd_reg(0, v); check(req, v, s);
        rd_reg(1, v); check(req, v, m);
        rd_reg(2, v); check(req, v, h);
        rd_reg(3, v); check(req, v, w);
        rd_reg(4, v); check(req, v, d);
        rd_reg(5, v); check(req, v, mo);
        rd_reg(6, v); check(req, v, y);
    endtask

    function automatic int to_bcd(input int x);
        return ((x / 10) << 4) | (x % 10);
    endfunction

    function automatic int model_sum();
        int s = 0;
        for (int i = 7; i <= 30; i++) s += model[i];
        return s & 8'hFF;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int v, c, exp_tick;
        for (int i = 7; i <= 30; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 status", status_o, 0);
        check("R1 rdbuf", rdbuf_o, 0);
        check("R1 irq/req", {irq, reset_req, poweroff_req}, 0);
        chk_cal("R1 calendar", 0, 0, 0, 0, 1, 1, 0);

        // R2 posted timing
        host_write(6, 8'h11);
        host_write(4, 8'h92);               // write idx 9
        check("R2 busy set", status_o[0], 1);
        wait_idle(c);
        check("R2 delay", c, DLY);
        check("R2 done", status_o[1], 1);
        model[9] = 8'h11;

        // R5 sweep over general indexes 9..30
        for (int i = 9; i <= 30; i++) begin
            wr_reg(i, (i * 37 + 5) & 8'hFF);
            model[i] = 8'((i * 37 + 5) & 8'hFF);
        end
        for (int i = 9; i <= 30; i++) begin
            rd_reg(i, v);
            check("R5 readback", v, model[i]);
        end

        // R7 checksum
        rd_reg(31, v);
        check("R7 checksum", v, model_sum());

        // R4 invalid command
        host_write(6, 8'hAB);
        access(1'b1, 9, 1'b1, c);
        check("R4 done on invalid", status_o[1:0], 2'b10);
        rd_reg(9, v);
        check("R4 no change", v, model[9]);

        // R3 command ignored while busy
        host_write(6, 8'h5C);
        host_write(4, {1'b0, 6'd12, 1'b0});  // read 12
        host_write(4, {1'b1, 6'd13, 1'b0});  // ignored
        wait_idle(c);
        check("R3 first command", rdbuf_o, model[12]);
        rd_reg(13, v);
        check("R3 second ignored", v, model[13]);

        // R6 out-of-bank indexes
        for (int i = 32; i <= 63; i++) wr_reg(i, 8'h77);
        for (int i = 32; i <= 39; i++) begin
            rd_reg(i, v);
            check("R6 reads zero", v, 0);
        end
        rd_reg(9, v);
        rd_reg(45, v);
        check("R6 rdbuf kept", v, model[9]);
        rd_reg(31, v);
        check("R6 checksum kept", v, model_sum());

        // R8 power-control
        wr_reg(7, 8'h5A);
        rd_reg(7, v);
        check("R8 low bits only", v, 8'h1A);
        check("R8 no request", n_rst + n_off, 0);
        wr_reg(7, 8'hC3);
        rd_reg(7, v);
        check("R8 reset code", v, 8'hC3);
        check("R8 reset pulse", n_rst, 1);
        wr_reg(7, 8'hE5);
        rd_reg(7, v);
        check("R8 poweroff code", v, 8'hC5);
        check("R8 poweroff pulse", {n_rst, n_off}, {32'd1, 32'd1});
        model[7] = 8'hC5;
        rd_reg(31, v);
        check("R7 checksum after power", v, model_sum());

        // R11 tick counter
        wr_reg(8, 8'hF0);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk); tick_32hz = 1'b1;
        end
        @(negedge clk); tick_32hz = 1'b0;
        exp_tick = (8'hF0 + 300) & 8'hFF;
        rd_reg(8, v);
        check("R11 tick count", v, exp_tick);

        // R12/R13 status clear and irq gating
        host_write(2, 16'h000E);
        check("R12 cleared", status_o, 0);
        host_write(0, 16'h0006);
        check("R13 idle irq", irq, 0);
        pulse1(1);
        check("R10 second flag", status_o[2], 1);
        check("R13 second irq", irq, 1);
        host_write(0, 16'h0002);
        check("R13 gated off", irq, 0);
        host_write(4, {1'b0, 6'd0, 1'b0});
        host_write(2, 16'h000F);
        check("R12 busy kept", status_o[0], 1);
        check("R12 second cleared", status_o[2], 0);
        wait_idle(c);
        check("R13 done irq", irq, 1);

        // R9 long run of seconds from midnight
        set_cal(0, 0, 0, 0, 1, 1, 0);
        pulse1(4000);
        chk_cal("R9 4000s", to_bcd(4000 % 60), to_bcd((4000 / 60) % 60),
                to_bcd(4000 / 3600), 0, 1, 1, 0);
        // year rollover
        set_cal(8'h59, 8'h59, 8'h23, 6, 8'h31, 8'h12, 8'h99);
        pulse1(1);
        chk_cal("R9 year wrap", 0, 0, 0, 0, 1, 1, 0);
        // leap February
        set_cal(8'h59, 8'h59, 8'h23, 2, 8'h28, 8'h02, 8'h24);
        pulse1(1);
        chk_cal("R9 leap 28", 0, 0, 0, 3, 8'h29, 8'h02, 8'h24);
        set_cal(8'h59, 8'h59, 8'h23, 3, 8'h29, 8'h02, 8'h24);
        pulse1(1);
        chk_cal("R9 leap 29", 0, 0, 0, 4, 1, 3, 8'h24);
        // common February and a 30-day month
        set_cal(8'h59, 8'h59, 8'h23, 1, 8'h28, 8'h02, 8'h23);
        pulse1(1);
        chk_cal("R9 common feb", 0, 0, 0, 2, 1, 3, 8'h23);
        set_cal(8'h59, 8'h59, 8'h23, 5, 8'h30, 8'h04, 8'h23);
        pulse1(1);
        chk_cal("R9 april", 0, 0, 0, 6, 1, 5, 8'h23);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule